// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between an on-chip request bus and an external byte-wide asynchronous static RAM. The external RAM has 524,288 words, so the address bus is 19 bits wide. Each accepted request is a single-word read or write. The controller turns it into the chip-select, output-enable and write-strobe sequence that the RAM expects. The data bus is bidirectional at the pad, and here it is split into an outgoing byte, an incoming byte and a drive enable.

Every strobe phase lasts a whole number of clock cycles, set by three parameters. `ACCESS_CYC` sets the read access wait. `WE_PULSE_CYC` sets the write strobe width. `TURN_CYC` sets the idle gap after a read. The defaults meet the fastest speed grade at a 10 ns clock: 17 ns access, 13 ns write pulse and 8 ns output float. Writes are timed by the write strobe while chip select stays low. The RAM latches the byte on the rising edge of the write strobe, and the controller keeps driving the data for one more clock after that edge. After a read, the RAM's output drivers must turn off before the controller drives the bus again, which the idle gap guarantees. Read data is registered on the final access clock and returned with a one-cycle response pulse.

Top module: `asram_ctrl`

## Requirements
- R1: During and right after reset: `req_ready`=1, `mem_ce_n`=1, `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0, `rsp_valid`=0.
- R2: A read accepted on a rising edge (`req_valid`=1, `req_ready`=1, `req_write`=0) holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for exactly `ACCESS_CYC` cycles after that edge, with `mem_addr` equal to the request address.
- R3: The read byte is sampled from `mem_dq_in` on the last access clock. It appears on `rsp_rdata` with `rsp_valid`=1 for exactly one cycle, which is the cycle right after the access phase.
- R4: After a read, `mem_ce_n` and `mem_oe_n` stay high for `TURN_CYC` cycles before the controller can accept new work. `mem_dq_oe` is never 1 while `mem_oe_n`=0. `mem_dq_oe` rises only when at least `TURN_CYC` cycles have passed since the RAM last drove the bus.
- R5: An accepted write holds `mem_we_n`=0 for exactly `WE_PULSE_CYC` cycles, with `mem_ce_n`=0 and `mem_oe_n`=1. `mem_addr` and `mem_dq_out` are stable and equal to the request for the whole pulse.
- R6: `mem_dq_oe` rises in the same cycle that `mem_we_n` falls, and stays 1 for one cycle after `mem_we_n` rises. `mem_ce_n` stays low during that cycle. At all other times `mem_dq_oe` is 0.
- R7: `req_ready` goes low on the edge that accepts a request. It stays low for `ACCESS_CYC`+`TURN_CYC` cycles for a read and `WE_PULSE_CYC`+1 cycles for a write, then returns high.
- R8: `req_valid` asserted while `req_ready`=0 has no effect. The RAM word it names keeps its old value.
- R9: A write never raises `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 8 | Read byte, held until next read |
| mem_addr | output | 19 | RAM address |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_dq_out | output | 8 | Byte driven toward the RAM |
| mem_dq_in | input | 8 | Byte read from the RAM pins |
| mem_dq_oe | output | 1 | Controller drives the data pins |

## Verification
The embedded properties check the following on every cycle:
- no overlap between controller drive and RAM output enable;
- the post-read gap before the bus is driven again;
- the exact write strobe width;
- stability of address and data under the strobe;
- the drive tail after the strobe rises;
- the single-cycle response pulse;
- the busy length for each request kind.

Only the bench's scenarios can show that the right bytes end up in the right words and come back on `rsp_rdata`. They also show that requests arriving while busy leave memory untouched, using a behavioural RAM model, a full address sweep and back-to-back read/write turnarounds.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_TURN,
    ST_WR,
    ST_HOLD
  } asram_st_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } asram_pins_t;

  // Pin levels held for the duration of each state.
  function automatic asram_pins_t pins_of(asram_st_e st);
    asram_pins_t p;
    case (st)
      ST_RD:   p = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, dq_oe: 1'b0};
      ST_WR:   p = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, dq_oe: 1'b1};
      ST_HOLD: p = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b1};
      default: p = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
    endcase
    return p;
  endfunction

  // Cycles with req_ready low after an accepted request.
  function automatic int unsigned busy_cycles(bit is_wr, int unsigned acc,
                                              int unsigned wp, int unsigned trn);
    return is_wr ? (wp + 1) : (acc + trn);
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/asram_fsm.sv
module asram_fsm
  import asram_pkg::*;
#(
  parameter int unsigned ACCESS_CYC   = 2,
  parameter int unsigned WE_PULSE_CYC = 2,
  parameter int unsigned TURN_CYC     = 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid,
  input  logic      req_write,
  output logic      req_ready,
  output logic      accept,
  output logic      capture,
  output asram_st_e st_nx
);

  localparam int unsigned MAXC  = max3(ACCESS_CYC, WE_PULSE_CYC, TURN_CYC);
  localparam int unsigned CNT_W = $clog2(MAXC + 1);
  localparam int unsigned BSY_W = $clog2(2 * MAXC + 2);

  asram_st_e        st_q;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             phase_end;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign phase_end = (cnt_q == '0);
  assign capture   = (st_q == ST_RD) && phase_end;

  always_comb begin
    st_nx  = st_q;
    cnt_nx = phase_end ? cnt_q : cnt_q - 1'b1;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        st_nx  = req_write ? ST_WR : ST_RD;
        cnt_nx = req_write ? CNT_W'(WE_PULSE_CYC - 1) : CNT_W'(ACCESS_CYC - 1);
      end
      ST_RD: if (phase_end) begin
        st_nx  = ST_TURN;
        cnt_nx = CNT_W'(TURN_CYC - 1);
      end
      ST_TURN: if (phase_end) st_nx = ST_IDLE;
      ST_WR: if (phase_end) begin
        st_nx  = ST_HOLD;
        cnt_nx = '0;
      end
      ST_HOLD: st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_nx;
      cnt_q <= cnt_nx;
    end
  end

  // Busy-length observer for the checks below.
  logic [BSY_W-1:0] busy_cnt;
  logic             last_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
      last_wr  <= 1'b0;
    end else if (accept) begin
      busy_cnt <= '0;
      last_wr  <= req_write;
    end else if (!req_ready) begin
      busy_cnt <= busy_cnt + 1'b1;
    end
  end

  p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |->
      (int'(busy_cnt) == int'(busy_cycles(last_wr, ACCESS_CYC, WE_PULSE_CYC, TURN_CYC))));

endmodule

// File: rtl/asram_pins.sv
module asram_pins
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W       = 19,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned WE_PULSE_CYC = 2,
  parameter int unsigned TURN_CYC     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  asram_st_e         st_nx,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);

  localparam int unsigned GAP_W = $clog2(TURN_CYC + 2);
  localparam int unsigned WEC_W = $clog2(WE_PULSE_CYC + 2);

  asram_pins_t pins_nx;
  assign pins_nx = pins_of(st_nx);

  // Strobes leave flops so the pads see clean edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      mem_ce_n  <= pins_nx.ce_n;
      mem_oe_n  <= pins_nx.oe_n;
      mem_we_n  <= pins_nx.we_n;
      mem_dq_oe <= pins_nx.dq_oe;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) rsp_rdata <= mem_dq_in;
    end
  end

  // Observers: cycles since the RAM last drove, and write strobe width.
  logic             ram_drives;
  logic [GAP_W-1:0] gap_q;
  logic [WEC_W-1:0] we_cnt;

  assign ram_drives = !mem_ce_n && !mem_oe_n && mem_we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= GAP_W'(TURN_CYC + 1);
      we_cnt <= '0;
    end else begin
      if (ram_drives)                          gap_q <= '0;
      else if (gap_q != GAP_W'(TURN_CYC + 1))  gap_q <= gap_q + 1'b1;
      if (mem_we_n)                                 we_cnt <= '0;
      else if (we_cnt != WEC_W'(WE_PULSE_CYC + 1))  we_cnt <= we_cnt + 1'b1;
    end
  end

  p_no_clash_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  p_turn_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (gap_q >= GAP_W'(TURN_CYC)));

  p_write_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n));

  p_we_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_cnt == WEC_W'(WE_PULSE_CYC)));

  p_wr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

  p_dq_lead_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $rose(mem_dq_oe));

  p_dq_tail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n) ##1 !mem_dq_oe);

  p_rsp_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W       = 19,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned ACCESS_CYC   = 2,
  parameter int unsigned WE_PULSE_CYC = 2,
  parameter int unsigned TURN_CYC     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);

  logic      accept;
  logic      capture;
  asram_st_e st_nx;

  asram_fsm #(
    .ACCESS_CYC  (ACCESS_CYC),
    .WE_PULSE_CYC(WE_PULSE_CYC),
    .TURN_CYC    (TURN_CYC)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_ready(req_ready),
    .accept   (accept),
    .capture  (capture),
    .st_nx    (st_nx)
  );

  asram_pins #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .WE_PULSE_CYC(WE_PULSE_CYC),
    .TURN_CYC    (TURN_CYC)
  ) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .capture   (capture),
    .st_nx     (st_nx),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_out(mem_dq_out),
    .mem_dq_in (mem_dq_in),
    .mem_dq_oe (mem_dq_oe)
  );

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !rsp_valid) |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

endmodule

// File: tb/asram_ctrl_bench.sv
module asram_ctrl_bench;

  localparam int ACC = 3;
  localparam int WP  = 2;
  localparam int TRN = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [18:0] req_addr;
  logic [7:0]  req_wdata;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [18:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  always #2 clk = ~clk;

  asram_ctrl #(
    .ACCESS_CYC(ACC), .WE_PULSE_CYC(WP), .TURN_CYC(TRN)
  ) u_asram_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
    .mem_dq_oe(mem_dq_oe)
  );

  // Behavioural RAM: 16 words indexed by the low address nibble.
  logic [7:0] ram [16];
  initial for (int i = 0; i < 16; i++) ram[i] = 8'h11;
  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? ram[mem_addr[3:0]] : 8'hEE;
  always @(posedge mem_we_n) if (mem_ce_n === 1'b0) ram[mem_addr[3:0]] <= mem_dq_out;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R4 monitor: cycles since the RAM drove, checked when controller drive starts.
  int  gap = 100;
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (mem_dq_oe && !prev_oe) chk(gap >= TRN, "R4 turnaround gap", gap, TRN);
      if (mem_dq_oe) chk(mem_oe_n == 1'b1, "R4 drive while oe low", mem_oe_n, 1);
      if (!mem_ce_n && !mem_oe_n && mem_we_n) gap = 0; else if (gap < 100) gap++;
      prev_oe = mem_dq_oe;
    end
  end

  function automatic logic [18:0] addr_of(int a);
    return {a[3:0], 11'h2B5, a[3:0]};
  endfunction

  function automatic logic [7:0] pat(int a, bit inv);
    logic [7:0] v;
    v = 8'(a * 37 + 5);
    return inv ? ~v : v;
  endfunction

  task automatic run_op(input bit wr, input logic [18:0] a, input logic [7:0] d,
                        input bit poke, output logic [7:0] got);
    int total;
    got = 8'h00;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    if (poke) begin
      req_write = 1'b1; req_addr = addr_of(9); req_wdata = 8'hC3;  // R8: ignored while busy
    end else begin
      req_valid = 1'b0;
    end
    total = wr ? WP + 1 : ACC + TRN;
    for (int s = 0; s <= total; s++) begin
      if (s > 0) @(negedge clk);
      if (s == total) req_valid = 1'b0;
      chk(req_ready == (s == total), "R7 ready window", req_ready, (s == total));
      if (wr) begin
        chk(mem_we_n == (s >= WP), "R5 write strobe", mem_we_n, (s >= WP));
        chk(mem_oe_n == 1'b1, "R5 oe high in write", mem_oe_n, 1);
        chk(mem_ce_n == (s > WP), "R6 select during write", mem_ce_n, (s > WP));
        chk(mem_dq_oe == (s <= WP), "R6 drive window", mem_dq_oe, (s <= WP));
        chk(rsp_valid == 1'b0, "R9 no response on write", rsp_valid, 0);
        if (s <= WP) begin
          chk(mem_addr == a, "R5 write address", mem_addr, a);
          chk(mem_dq_out == d, "R5 write data", mem_dq_out, d);
        end
      end else begin
        chk(mem_ce_n == (s >= ACC), "R2 read select", mem_ce_n, (s >= ACC));
        chk(mem_oe_n == (s >= ACC), "R2 R4 read oe", mem_oe_n, (s >= ACC));
        chk(mem_we_n == 1'b1, "R2 we high in read", mem_we_n, 1);
        chk(mem_dq_oe == 1'b0, "R4 no drive in read", mem_dq_oe, 0);
        chk(rsp_valid == (s == ACC), "R3 response pulse", rsp_valid, (s == ACC));
        if (s < ACC) chk(mem_addr == a, "R2 read address", mem_addr, a);
        if (s == ACC) got = rsp_rdata;
      end
    end
  endtask

  initial begin
    logic [7:0] got;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(req_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid,
        "R1 state in reset", {req_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_valid}, 6'b111100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid,
        "R1 state after reset", {req_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_valid}, 6'b111100);

    // Sweep: write then read every word (read-to-write turnaround each step).
    for (int a = 0; a < 16; a++) begin
      run_op(1'b1, addr_of(a), pat(a, 0), 1'b0, got);
      run_op(1'b0, addr_of(a), 8'h00, 1'b0, got);
      chk(got == pat(a, 0), "R3 read data", got, pat(a, 0));
    end
    // Second pass, inverted pattern, read back in reverse order.
    for (int a = 0; a < 16; a++) run_op(1'b1, addr_of(a), pat(a, 1), 1'b0, got);
    for (int a = 15; a >= 0; a--) begin
      run_op(1'b0, addr_of(a), 8'h00, 1'b0, got);
      chk(got == pat(a, 1), "R3 read data reverse", got, pat(a, 1));
    end
    // R8: requests held during busy periods must not be taken.
    run_op(1'b0, addr_of(3), 8'h00, 1'b1, got);
    chk(got == pat(3, 1), "R8 read with busy poke", got, pat(3, 1));
    run_op(1'b1, addr_of(4), 8'h5A, 1'b1, got);
    run_op(1'b0, addr_of(9), 8'h00, 1'b0, got);
    chk(got == pat(9, 1), "R8 word 9 untouched", got, pat(9, 1));
    run_op(1'b0, addr_of(4), 8'h00, 1'b0, got);
    chk(got == 8'h5A, "R8 poked write landed once", got, 8'h5A);

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule